// File: doc/BRIEF.md
# Load/Store Queue Admission Tracker

This block keeps the occupancy of a load queue and a store queue and decides, cycle by cycle, whether the memory instruction offered at dispatch can take its entries. A load or a load barrier needs one load-queue entry. A store or a store barrier needs one store-queue entry. An instruction that both reads and writes memory needs one of each. An instruction that touches no memory always passes. Loads give their entry back on a release pulse at retirement, and stores give theirs back on a release pulse at commit. Ordering between instructions is not decided here.

The dispatch request is a valid/ready stream. `disp_ready` is a combinational function of the current occupancy and of the request's access flags, and it never depends on `disp_valid`. The dispatch stage may hold `disp_valid` high across cycles while ready is low. A transfer happens on every rising edge at which valid and ready are both high. The 2-bit status code explains a low ready. A configured size of zero makes a queue unbounded, and only the counter's own ceiling can then hold back admission. The configured sizes are sampled continuously and are meant to be changed only while the block is in reset.

Top module: `lsq_admit_tracker`

## Requirements
- R1: After reset, both used counts are 0, both empty flags are 1, both full flags are 0 and the error flag is 0.
- R2: The status code is 0 (available), 1 (load queue cannot accept) or 2 (store queue cannot accept). `disp_ready` is 1 exactly when the status is 0.
- R3: A request with neither access flag set gets status 0, is accepted, and changes neither count.
- R4: An accepted request with the load flag set adds one to the load count. One with the store flag set adds one to the store count. The new count appears on the output after the next rising edge.
- R5: A queue's full flag is 1 when its size is nonzero and its count equals its size. Its empty flag is 1 when its count is 0.
- R6: A request with both flags set is accepted only when both queues can take an entry. When neither can, the status is 1.
- R7: With a size of 0, the full flag stays 0 at any count. Such a queue blocks only at the count ceiling 2^CNT_W-1, where it reports its own status code.
- R8: A release pulse on a non-empty queue subtracts one from its count. An accepted dispatch and a release on the same queue in the same cycle leave that count unchanged.
- R9: A release pulse on an empty queue leaves that count unaffected and sets the error flag. The flag stays set until reset.
- R10: The status and ready outputs respond to the request flags in the same cycle, using the counts registered at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lq_size | input | CNT_W | Load queue size, 0 = unbounded |
| cfg_sq_size | input | CNT_W | Store queue size, 0 = unbounded |
| disp_valid | input | 1 | Dispatch request present |
| disp_ready | output | 1 | Request can be accepted this cycle |
| disp_may_load | input | 1 | Request needs a load-queue entry |
| disp_may_store | input | 1 | Request needs a store-queue entry |
| ld_release | input | 1 | One load leaves the load queue |
| st_release | input | 1 | One store leaves the store queue |
| status | output | 2 | Admission code 0/1/2 |
| lq_used | output | CNT_W | Load queue entries in use |
| sq_used | output | CNT_W | Store queue entries in use |
| lq_empty | output | 1 | Load queue empty |
| lq_full | output | 1 | Load queue full |
| sq_empty | output | 1 | Store queue empty |
| sq_full | output | 1 | Store queue full |
| release_err | output | 1 | Sticky: release seen on an empty queue |

## Verification
A count that drifts shows on the used outputs one edge after the faulty update. The same drift then shows in the empty and full flags, and in status and ready in the same cycle, whenever the next request's flags touch that queue. A lost release or a double count therefore appears either as a numeric mismatch right away or as a wrong admission at the queue boundary. The bench compares every output on every cycle against its own model, so any divergence is caught within one clock. A wrong error-flag state is likewise visible one edge after the offending release and stays visible until reset.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef enum logic [1:0] {
    ADM_OK       = 2'd0,
    ADM_LQ_BLOCK = 2'd1,
    ADM_SQ_BLOCK = 2'd2
  } adm_status_e;

  localparam int unsigned NUM_QUEUES = 2;
  localparam int unsigned Q_LOAD     = 0;
  localparam int unsigned Q_STORE    = 1;

endpackage

// File: rtl/lsq_occ_counter.sv
module lsq_occ_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] size,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] used,
  output logic             empty,
  output logic             full,
  output logic             at_cap,
  output logic             underflow
);

  localparam logic [CNT_W-1:0] CAP = {CNT_W{1'b1}};

  logic             dec_ok;
  logic [CNT_W-1:0] used_d;

  // a release is honoured only when there is something to release
  assign dec_ok = dec && (used != '0);

  always_comb begin
    used_d = used;
    unique case ({inc, dec_ok})
      2'b10:   used_d = used + 1'b1;
      2'b01:   used_d = used - 1'b1;
      default: used_d = used;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used      <= '0;
      underflow <= 1'b0;
    end else begin
      used <= used_d;
      if (dec && (used == '0)) underflow <= 1'b1;
    end
  end

  assign empty  = (used == '0);
  assign full   = (size != '0) && (used == size);
  assign at_cap = (used == CAP);

  // R9
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && used == '0) |=> (used == '0) && underflow);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R8
  same_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && used != '0) |=> $stable(used));

  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> (used == $past(used) + 1'b1));

endmodule

// File: rtl/lsq_admit_arb.sv
module lsq_admit_arb
  import lsq_pkg::*;
(
  input  logic        need_ld,
  input  logic        need_st,
  input  logic        lq_block,
  input  logic        sq_block,
  output adm_status_e code,
  output logic        grant
);

  logic ld_stop;
  logic st_stop;

  assign ld_stop = need_ld && lq_block;
  assign st_stop = need_st && sq_block;

  // load-side refusal outranks store-side refusal
  always_comb begin
    if (ld_stop)      code = ADM_LQ_BLOCK;
    else if (st_stop) code = ADM_SQ_BLOCK;
    else              code = ADM_OK;
  end

  assign grant = !ld_stop && !st_stop;

endmodule

// File: rtl/lsq_admit_tracker.sv
module lsq_admit_tracker
  import lsq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_lq_size,
  input  logic [CNT_W-1:0] cfg_sq_size,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic             disp_may_load,
  input  logic             disp_may_store,
  input  logic             ld_release,
  input  logic             st_release,
  output logic [1:0]       status,
  output logic [CNT_W-1:0] lq_used,
  output logic [CNT_W-1:0] sq_used,
  output logic             lq_empty,
  output logic             lq_full,
  output logic             sq_empty,
  output logic             sq_full,
  output logic             release_err
);

  logic [CNT_W-1:0] q_size  [NUM_QUEUES];
  logic [CNT_W-1:0] q_used  [NUM_QUEUES];
  logic             q_need  [NUM_QUEUES];
  logic             q_rel   [NUM_QUEUES];
  logic             q_empty [NUM_QUEUES];
  logic             q_full  [NUM_QUEUES];
  logic             q_cap   [NUM_QUEUES];
  logic             q_err   [NUM_QUEUES];
  logic             q_block [NUM_QUEUES];
  logic             accept;
  logic             grant;
  adm_status_e      code;

  assign q_size[Q_LOAD]  = cfg_lq_size;
  assign q_size[Q_STORE] = cfg_sq_size;
  assign q_need[Q_LOAD]  = disp_may_load;
  assign q_need[Q_STORE] = disp_may_store;
  assign q_rel[Q_LOAD]   = ld_release;
  assign q_rel[Q_STORE]  = st_release;

  assign accept = disp_valid && grant;

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
    lsq_occ_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .size      (q_size[q]),
      .inc       (accept && q_need[q]),
      .dec       (q_rel[q]),
      .used      (q_used[q]),
      .empty     (q_empty[q]),
      .full      (q_full[q]),
      .at_cap    (q_cap[q]),
      .underflow (q_err[q])
    );
    assign q_block[q] = q_full[q] || q_cap[q];
  end

  lsq_admit_arb u_arb (
    .need_ld  (disp_may_load),
    .need_st  (disp_may_store),
    .lq_block (q_block[Q_LOAD]),
    .sq_block (q_block[Q_STORE]),
    .code     (code),
    .grant    (grant)
  );

  assign disp_ready  = grant;
  assign status      = code;
  assign lq_used     = q_used[Q_LOAD];
  assign sq_used     = q_used[Q_STORE];
  assign lq_empty    = q_empty[Q_LOAD];
  assign lq_full     = q_full[Q_LOAD];
  assign sq_empty    = q_empty[Q_STORE];
  assign sq_full     = q_full[Q_STORE];
  assign release_err = q_err[Q_LOAD] || q_err[Q_STORE];

  // R3
  no_mem_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_may_load && !disp_may_store) |-> (status == 2'd0) && disp_ready);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && disp_may_load) |-> !lq_full);

  // R5
  no_st_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && disp_may_store) |-> !sq_full);

  // R6
  both_full_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_may_load && disp_may_store && lq_full && sq_full) |-> (status == 2'd1));

  // R7
  unbounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lq_size == '0) |-> !lq_full);

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'd3) && (disp_ready == (status == 2'd0)));

endmodule

// File: tb/tb_lsq_admit_tracker.sv
module tb_lsq_admit_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int CEIL       = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_lq_size = '0;
  logic [CNT_W-1:0] cfg_sq_size = '0;
  logic             disp_valid = 1'b0;
  logic             disp_ready;
  logic             disp_may_load = 1'b0;
  logic             disp_may_store = 1'b0;
  logic             ld_release = 1'b0;
  logic             st_release = 1'b0;
  logic [1:0]       status;
  logic [CNT_W-1:0] lq_used, sq_used;
  logic             lq_empty, lq_full, sq_empty, sq_full, release_err;

  int tests = 0;
  int fails = 0;
  int m_lq = 0, m_sq = 0, m_lsz = 0, m_ssz = 0;
  bit m_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsq_admit_tracker #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_lq_size(cfg_lq_size), .cfg_sq_size(cfg_sq_size),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_may_load(disp_may_load), .disp_may_store(disp_may_store),
    .ld_release(ld_release), .st_release(st_release), .status(status),
    .lq_used(lq_used), .sq_used(sq_used), .lq_empty(lq_empty), .lq_full(lq_full),
    .sq_empty(sq_empty), .sq_full(sq_full), .release_err(release_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_status(bit ld, bit st);
    bit lb = ld && ((m_lsz != 0 && m_lq == m_lsz) || m_lq == CEIL);
    bit sb = st && ((m_ssz != 0 && m_sq == m_ssz) || m_sq == CEIL);
    if (lb) return 1;
    if (sb) return 2;
    return 0;
  endfunction

  task automatic compare_all(input string ph);
    int es = exp_status(disp_may_load, disp_may_store);
    check(status == es, {"R2/R10 ", ph}, "status", status, es);
    check(disp_ready == (es == 0), {"R2 ", ph}, "ready", disp_ready, es == 0);
    check(lq_used == m_lq, {"R4 ", ph}, "lq_used", lq_used, m_lq);
    check(sq_used == m_sq, {"R4 ", ph}, "sq_used", sq_used, m_sq);
    check(lq_empty == (m_lq == 0), {"R5 ", ph}, "lq_empty", lq_empty, m_lq == 0);
    check(sq_empty == (m_sq == 0), {"R5 ", ph}, "sq_empty", sq_empty, m_sq == 0);
    check(lq_full == (m_lsz != 0 && m_lq == m_lsz), {"R5/R7 ", ph}, "lq_full",
          lq_full, m_lsz != 0 && m_lq == m_lsz);
    check(sq_full == (m_ssz != 0 && m_sq == m_ssz), {"R5/R7 ", ph}, "sq_full",
          sq_full, m_ssz != 0 && m_sq == m_ssz);
    check(release_err == m_err, {"R9 ", ph}, "release_err", release_err, m_err);
  endtask

  // one cycle: drive, compare before the edge, then advance the model
  task automatic step(input bit v, input bit ld, input bit st,
                      input bit lr, input bit sr, input string ph);
    bit acc;
    @(negedge clk);
    disp_valid = v; disp_may_load = ld; disp_may_store = st;
    ld_release = lr; st_release = sr;
    #1;
    compare_all(ph);
    acc = v && (exp_status(ld, st) == 0);
    @(posedge clk);
    if (lr && m_lq == 0) m_err = 1;
    if (sr && m_sq == 0) m_err = 1;
    m_lq = m_lq + ((acc && ld) ? 1 : 0) - ((lr && m_lq != 0) ? 1 : 0);
    m_sq = m_sq + ((acc && st) ? 1 : 0) - ((sr && m_sq != 0) ? 1 : 0);
  endtask

  task automatic do_reset(input int lsz, input int ssz);
    @(negedge clk);
    rst_n = 0; disp_valid = 0; ld_release = 0; st_release = 0;
    disp_may_load = 0; disp_may_store = 0;
    cfg_lq_size = lsz[CNT_W-1:0]; cfg_sq_size = ssz[CNT_W-1:0];
    repeat (2) @(posedge clk);
    m_lq = 0; m_sq = 0; m_err = 0; m_lsz = lsz; m_ssz = ssz;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    do_reset(4, 3);
    step(0, 0, 0, 0, 0, "R1 reset state");

    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, "R4 fill loads");
    step(1, 1, 0, 0, 0, "R2 load blocked code 1");
    step(1, 0, 1, 0, 0, "R6 store passes with full lq");
    step(1, 1, 1, 0, 0, "R6 both-access blocked by lq");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, "R4 fill stores");
    step(1, 0, 1, 0, 0, "R2 store blocked code 2");
    step(1, 1, 1, 0, 0, "R6 both full gives code 1");
    step(1, 0, 0, 0, 0, "R3 non-memory accepted with both full");
    step(1, 0, 0, 0, 0, "R3 counts unchanged");
    step(1, 1, 0, 1, 0, "R8 release while full");
    step(1, 1, 0, 1, 0, "R8 dispatch plus release same queue");
    step(1, 0, 1, 0, 1, "R8 store dispatch plus release");
    step(0, 0, 0, 1, 1, "R8 release both");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, "R8 drain");
    step(0, 0, 0, 1, 0, "R9 release on empty lq");
    step(1, 1, 1, 0, 0, "R9 count unaffected, flag sticky");
    step(0, 0, 0, 0, 1, "R9 flag stays");
    step(1, 1, 0, 1, 0, "R10 same-cycle status");

    do_reset(0, 1);
    step(0, 0, 0, 0, 0, "R1 reset clears error");
    step(0, 0, 0, 0, 1, "R9 store-side underflow");
    step(1, 0, 1, 0, 1, "R9 dispatch with release on empty sq");
    for (int i = 0; i < CEIL + 2; i++) step(1, 1, 0, 0, 0, "R7 unbounded load queue");
    step(1, 1, 1, 0, 0, "R7 ceiling reports code 1");

    do_reset(5, 2);
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], lfsr[2], lfsr[3] & lfsr[4], lfsr[5] & lfsr[6],
           "R10 mixed traffic");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule